// File: doc/BRIEF.md
# Overlapped Translation and Physically Tagged Cache Lookup

This block is the first-level data lookup: a small translation buffer and a direct-mapped cache are read in the same cycle. The cache holds exactly one page's worth of lines. Its index therefore comes entirely from the page-offset bits of the virtual address, and those bits are the same before and after translation. The virtual page number goes to the fully associative translation buffer at the same moment. Each cache line keeps the physical page number of its data as a tag.

Both array reads finish in the request cycle, and their results are registered. In the following cycle, the physical page number from the translation buffer is compared with the tag of the line that was read, and the block reports one of three outcomes: a hit with the data word, a translation miss, or a cache miss.

The translation buffer is loaded through a fill port that writes entries in round-robin order. Each cache line is loaded through a separate fill port. A single invalidate pulse or a reset empties both arrays. Each line holds one data word, so the four byte-offset bits below the index do not affect the result.

Top module: `overlap_tlb_cache`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_tlb_miss` and `rsp_cache_miss` are 0, and every entry of both arrays is invalid, so any request gives a translation miss.
- R2: A request sampled with `req_valid` at a clock edge produces `rsp_valid`=1 for exactly the following cycle. Without a request, `rsp_valid` and all three outcome flags are 0.
- R3: While `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_tlb_miss` and `rsp_cache_miss` is 1.
- R4: `rsp_tlb_miss` is 1 when no valid translation entry holds the virtual page number `req_vaddr[31:12]`, whatever the state of the cache line.
- R5: The cache index is `req_vaddr[11:4]`, used without translation, and `req_vaddr[3:0]` has no effect. Two virtual pages that map to the same physical page reach the same line.
- R6: `rsp_hit` is 1 only when the translation hits, the indexed line is valid, and its stored tag equals the translated physical page number. On a hit, `rsp_data` is the line's word and `rsp_ppn` is the translated page number.
- R7: `rsp_cache_miss` is 1 when the translation hits but the indexed line is invalid, or holds a different physical tag.
- R8: Translation fills go to entries 0, 1, 2 … 7 in turn, starting from entry 0 after reset, and then wrap. The ninth fill replaces the mapping written by the first.
- R9: `inval_all` clears every valid bit in both arrays in one cycle. A fill in the same cycle as `inval_all` is discarded.
- R10: A request in the same cycle as a fill or an invalidate sees the array contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_all | input | 1 | Clear all valid bits of both arrays |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the lookup |
| tlb_fill_en | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | 20 | Virtual page number to store |
| tlb_fill_ppn | input | 20 | Physical page number to store |
| cache_fill_en | input | 1 | Write one cache line |
| cache_fill_idx | input | 8 | Line index to write |
| cache_fill_tag | input | 20 | Physical page tag for the line |
| cache_fill_data | input | 32 | Data word for the line |
| cache_fill_valid | input | 1 | Valid bit written with the line |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Valid cache hit |
| rsp_tlb_miss | output | 1 | No matching translation |
| rsp_cache_miss | output | 1 | Translation hit, but line invalid or tag mismatch |
| rsp_ppn | output | 20 | Translated physical page number |
| rsp_data | output | 32 | Data word of the indexed line |

## Verification
The lookup is exercised with several address patterns:
- Matching page and tag, which gives a hit.
- An unmapped page whose indexed line is valid, which shows that the translation miss takes priority.
- A mapped page whose line is empty or carries another tag, which separates the two kinds of cache miss.
- Two virtual pages that alias one physical page, which shows that indexing uses only untranslated bits.

Changing only the byte-offset bits shows that they are ignored. Nine translation fills show where the round-robin replacement lands. Requests issued in the same cycle as fills or an invalidate show that a lookup reads the contents from before that edge.

// File: rtl/overlap_tlb_cache.sv
module overlap_tlb_cache #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 4,
  parameter int TLB_N     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inval_all,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic                        tlb_fill_en,
  input  logic [VA_W-PAGE_BITS-1:0]   tlb_fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0]   tlb_fill_ppn,
  input  logic                        cache_fill_en,
  input  logic [PAGE_BITS-LINE_BITS-1:0] cache_fill_idx,
  input  logic [PA_W-PAGE_BITS-1:0]   cache_fill_tag,
  input  logic [DATA_W-1:0]           cache_fill_data,
  input  logic                        cache_fill_valid,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_tlb_miss,
  output logic                        rsp_cache_miss,
  output logic [PA_W-PAGE_BITS-1:0]   rsp_ppn,
  output logic [DATA_W-1:0]           rsp_data
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = PAGE_BITS - LINE_BITS;
  localparam int LINES = 1 << IDX_W;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [VPN_W-1:0]  tlb_vpn [TLB_N];
  logic [PPN_W-1:0]  tlb_ppn [TLB_N];
  logic [TLB_N-1:0]  tlb_vld;
  logic [PTR_W-1:0]  rr_ptr;

  logic [PPN_W-1:0]  line_tag  [LINES];
  logic [DATA_W-1:0] line_data [LINES];
  logic [LINES-1:0]  line_vld;

  logic [VPN_W-1:0]  req_vpn;
  logic [IDX_W-1:0]  req_idx;
  logic              unused_offset;

  assign req_vpn       = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_idx       = req_vaddr[PAGE_BITS-1:LINE_BITS];
  assign unused_offset = ^req_vaddr[LINE_BITS-1:0];

  // translation side: associative match on the page number
  logic [TLB_N-1:0] tlb_match;
  logic             tlb_hit_d;
  logic [PPN_W-1:0] tlb_ppn_d;

  for (genvar g = 0; g < TLB_N; g++) begin : g_match
    assign tlb_match[g] = tlb_vld[g] && (tlb_vpn[g] == req_vpn);
  end

  always_comb begin
    tlb_hit_d = 1'b0;
    tlb_ppn_d = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (tlb_match[i]) begin
        tlb_hit_d = 1'b1;
        tlb_ppn_d = tlb_ppn[i];
      end
    end
  end

  // cache side: indexed by untranslated offset bits in the same cycle
  logic              line_vld_d;
  logic [PPN_W-1:0]  line_tag_d;
  logic [DATA_W-1:0] line_data_d;

  assign line_vld_d  = line_vld[req_idx];
  assign line_tag_d  = line_tag[req_idx];
  assign line_data_d = line_data[req_idx];

  // fills and invalidation
  logic tlb_wr, line_wr;
  assign tlb_wr  = tlb_fill_en   && !inval_all;
  assign line_wr = cache_fill_en && !inval_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlb_vld <= '0;
      rr_ptr  <= '0;
    end else if (inval_all) begin
      tlb_vld <= '0;
    end else if (tlb_wr) begin
      tlb_vld[rr_ptr] <= 1'b1;
      rr_ptr <= (rr_ptr == PTR_W'(TLB_N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tlb_wr) begin
      tlb_vpn[rr_ptr] <= tlb_fill_vpn;
      tlb_ppn[rr_ptr] <= tlb_fill_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_vld <= '0;
    else if (inval_all)  line_vld <= '0;
    else if (line_wr)    line_vld[cache_fill_idx] <= cache_fill_valid;
  end

  always_ff @(posedge clk) begin
    if (line_wr) begin
      line_tag[cache_fill_idx]  <= cache_fill_tag;
      line_data[cache_fill_idx] <= cache_fill_data;
    end
  end

  // stage register between the array reads and the late compare
  logic              req_q, tlb_hit_q, line_vld_q;
  logic [PPN_W-1:0]  ppn_q, tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      tlb_hit_q  <= 1'b0;
      line_vld_q <= 1'b0;
      ppn_q      <= '0;
      tag_q      <= '0;
      data_q     <= '0;
    end else begin
      req_q      <= req_valid;
      tlb_hit_q  <= tlb_hit_d;
      line_vld_q <= line_vld_d;
      ppn_q      <= tlb_ppn_d;
      tag_q      <= line_tag_d;
      data_q     <= line_data_d;
    end
  end

  logic tag_eq;
  assign tag_eq = (tag_q == ppn_q);

  assign rsp_valid      = req_q;
  assign rsp_tlb_miss   = req_q && !tlb_hit_q;
  assign rsp_hit        = req_q && tlb_hit_q && line_vld_q && tag_eq;
  assign rsp_cache_miss = req_q && tlb_hit_q && !(line_vld_q && tag_eq);
  assign rsp_ppn        = ppn_q;
  assign rsp_data       = data_q;
endmodule

module overlap_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic inval_all,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_tlb_miss,
  input logic rsp_cache_miss
);
  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_tlb_miss, rsp_cache_miss}));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_tlb_miss || rsp_cache_miss));

  // R9
  after_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(inval_all)) |=> rsp_tlb_miss);
endmodule

bind overlap_tlb_cache overlap_lookup_chk u_lookup_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .inval_all(inval_all),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss),
  .rsp_cache_miss(rsp_cache_miss)
);

// File: tb/test_overlap_tlb_cache.sv
module test_overlap_tlb_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inval_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        tlb_fill_en = 1'b0;
  logic [19:0] tlb_fill_vpn = '0;
  logic [19:0] tlb_fill_ppn = '0;
  logic        cache_fill_en = 1'b0;
  logic [7:0]  cache_fill_idx = '0;
  logic [19:0] cache_fill_tag = '0;
  logic [31:0] cache_fill_data = '0;
  logic        cache_fill_valid = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_tlb_miss, rsp_cache_miss;
  logic [19:0] rsp_ppn;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  overlap_tlb_cache i_overlap_tlb_cache (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_fill_en(tlb_fill_en), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
    .cache_fill_en(cache_fill_en), .cache_fill_idx(cache_fill_idx),
    .cache_fill_tag(cache_fill_tag), .cache_fill_data(cache_fill_data),
    .cache_fill_valid(cache_fill_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss),
    .rsp_cache_miss(rsp_cache_miss), .rsp_ppn(rsp_ppn), .rsp_data(rsp_data)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tlb_fill(logic [19:0] vpn, logic [19:0] ppn);
    tlb_fill_en = 1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
    @(negedge clk);
    tlb_fill_en = 0;
  endtask

  task automatic line_fill(logic [7:0] idx, logic [19:0] tag, logic [31:0] data, logic v);
    cache_fill_en = 1; cache_fill_idx = idx; cache_fill_tag = tag;
    cache_fill_data = data; cache_fill_valid = v;
    @(negedge clk);
    cache_fill_en = 0;
  endtask

  // outcome code: 0 hit, 1 tlb miss, 2 cache miss
  task automatic lookup(string req, logic [31:0] va, int outcome,
                        logic [19:0] ppn, logic [31:0] data);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R3", "one outcome", 32'(rsp_hit + rsp_tlb_miss + rsp_cache_miss), 32'd1);
    chk(req, "hit", 32'(rsp_hit), 32'(outcome == 0));
    chk(req, "tlb_miss", 32'(rsp_tlb_miss), 32'(outcome == 1));
    chk(req, "cache_miss", 32'(rsp_cache_miss), 32'(outcome == 2));
    if (outcome == 0) begin
      chk(req, "ppn", 32'(rsp_ppn), 32'(ppn));
      chk(req, "data", rsp_data, data);
    end
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "flags", 32'({rsp_hit, rsp_tlb_miss, rsp_cache_miss}), 0);
    lookup("R1", 32'h0000_1000, 1, 0, 0);
    @(negedge clk);
    chk("R2", "idle rsp_valid", 32'(rsp_valid), 0);
    chk("R2", "idle flags", 32'({rsp_hit, rsp_tlb_miss, rsp_cache_miss}), 0);
  endtask

  task automatic t_hit;
    tlb_fill(20'h12345, 20'hABCDE);
    line_fill(8'h67, 20'hABCDE, 32'hDEADBEEF, 1);
    lookup("R6", 32'h1234_5678, 0, 20'hABCDE, 32'hDEADBEEF);
    lookup("R5", 32'h1234_567C, 0, 20'hABCDE, 32'hDEADBEEF);
    lookup("R5", 32'h1234_5670, 0, 20'hABCDE, 32'hDEADBEEF);
  endtask

  task automatic t_cache_miss;
    lookup("R7", 32'h1234_5688, 2, 0, 0);
    line_fill(8'h68, 20'h11111, 32'h0BAD0BAD, 1);
    lookup("R7", 32'h1234_5688, 2, 0, 0);
    line_fill(8'h69, 20'hABCDE, 32'h01234567, 0);
    lookup("R7", 32'h1234_5698, 2, 0, 0);
  endtask

  task automatic t_alias_and_unmapped;
    tlb_fill(20'h00077, 20'hABCDE);
    lookup("R5", 32'h0007_7678, 0, 20'hABCDE, 32'hDEADBEEF);
    lookup("R4", 32'h2222_2678, 1, 0, 0);
  endtask

  task automatic t_same_cycle;
    req_valid = 1; req_vaddr = 32'h1234_5688;
    cache_fill_en = 1; cache_fill_idx = 8'h68; cache_fill_tag = 20'hABCDE;
    cache_fill_data = 32'h55555555; cache_fill_valid = 1;
    @(negedge clk);
    req_valid = 0; cache_fill_en = 0;
    chk("R10", "old line seen", 32'(rsp_cache_miss), 1);
    lookup("R10", 32'h1234_5688, 0, 20'hABCDE, 32'h55555555);
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 6; i++) tlb_fill(20'h30000 + 20'(i), 20'h40000 + 20'(i));
    lookup("R8", 32'h1234_5678, 0, 20'hABCDE, 32'hDEADBEEF);
    tlb_fill(20'h50000, 20'hABCDE);
    lookup("R8", 32'h1234_5678, 1, 0, 0);
    lookup("R8", 32'h0007_7678, 0, 20'hABCDE, 32'hDEADBEEF);
    lookup("R8", 32'h5000_0678, 0, 20'hABCDE, 32'hDEADBEEF);
  endtask

  task automatic t_inval;
    req_valid = 1; req_vaddr = 32'h0007_7678; inval_all = 1;
    @(negedge clk);
    req_valid = 0; inval_all = 0;
    chk("R10", "req with inval sees old", 32'(rsp_hit), 1);
    lookup("R9", 32'h0007_7678, 1, 0, 0);
    tlb_fill(20'h00077, 20'hABCDE);
    lookup("R9", 32'h0007_7678, 2, 0, 0);
    inval_all = 1; tlb_fill_en = 1; tlb_fill_vpn = 20'h66666; tlb_fill_ppn = 20'hABCDE;
    cache_fill_en = 1; cache_fill_idx = 8'h67; cache_fill_tag = 20'hABCDE;
    cache_fill_data = 32'h77777777; cache_fill_valid = 1;
    @(negedge clk);
    inval_all = 0; tlb_fill_en = 0; cache_fill_en = 0;
    lookup("R9", 32'h6666_6678, 1, 0, 0);
    tlb_fill(20'h66666, 20'hABCDE);
    lookup("R9", 32'h6666_6678, 2, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_hit;
    t_cache_miss;
    t_alias_and_unmapped;
    t_same_cycle;
    t_round_robin;
    t_inval;
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule